// File: doc/BRIEF.md
# Infrared Pulse-Width Run-Length Capture

The block watches a digital infrared receiver output and turns the durations of its high and low levels into a stream of run-length bytes. A programmable divider produces a sample tick. On every tick the input level is taken, and the block counts how many consecutive ticks each level lasts. When a level ends, one byte is written into a 64-entry receive queue. The top bit of the byte holds the polarity of the finished level and the low seven bits hold its length. A level longer than one byte can express is split into several bytes of the same polarity.

Short disturbances are filtered by a noise threshold. A change of level must persist for a programmable number of ticks before it is believed. Samples of a rejected glitch are counted as part of the run they interrupted. Capture starts only at the first believed level change after enable, so the idle level that precedes a burst never produces a byte. Software drains the queue through a show-ahead read port. It sees the fill level, a fill-threshold interrupt and a sticky overflow flag.

The input is expected to be synchronous to `clk` already. Decoding of any remote-control protocol is left to software.

Top module: `irRleRx`

## Requirements
- R1: While `enable` is high, a sample tick occurs every `sampleDiv`+1 clock cycles, and the input is examined only on ticks. The divider restarts from zero whenever `enable` is low.
- R2: Each queue byte carries the polarity of the finished run in bit 7, where 1 means high and 0 means low. Bits 6:0 hold the run length minus one, so code 0 is 1 sample and code 127 is 128 samples.
- R3: A run longer than 128 samples emits byte {polarity, 7'h7f} for each complete 128 samples. Its remainder is emitted with the same polarity when the level ends.
- R4: A level change is accepted on the tick where it has been seen for `noiseThr` consecutive ticks; values 0 and 1 accept it at once. A shorter change is ignored and its samples count toward the current run. On acceptance the samples of the new level already seen start the new run.
- R5: After `enable` rises, the first tick records the idle level, and no byte is written until the first accepted change has ended another run. The idle level itself never produces a byte.
- R6: Dropping `enable` discards the run in progress without writing a byte. The queue contents are kept.
- R7: The queue holds 64 bytes in first-in first-out order. `rdData` shows the oldest byte while `fifoEmpty` is low, and `rdEn` removes it. `rdEn` on an empty queue has no effect, and `fifoLevel` gives the number of stored bytes (0 to 64).
- R8: `fifoIrq` is high exactly when `fifoThr` is non-zero and `fifoLevel` is at least `fifoThr`.
- R9: A byte produced while the queue holds 64 entries is dropped and sets `overflow`. `overflow` stays set until a cycle with `ovfClr` high, and a new drop in that same cycle wins over the clear.
- R10: After reset the queue is empty, `fifoLevel` is 0, and `overflow` and `fifoIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| irIn | input | 1 | Infrared receiver level, synchronous to clk |
| sampleDiv | input | 12 | Sample period minus one, in clock cycles |
| noiseThr | input | 7 | Ticks a new level must persist before acceptance |
| fifoThr | input | 7 | Fill level that raises the interrupt; 0 disables it |
| rdEn | input | 1 | Pop the oldest byte |
| ovfClr | input | 1 | Clear the overflow flag |
| rdData | output | 8 | Oldest queued byte (show-ahead) |
| fifoEmpty | output | 1 | Queue is empty |
| fifoLevel | output | 7 | Number of queued bytes |
| fifoIrq | output | 1 | Fill-threshold interrupt |
| overflow | output | 1 | Sticky drop indication |

## Verification
The embedded properties check, on every cycle, several invariants. Ticks never happen while disabled, and back-to-back ticks occur only with a divider of zero. The confirmed part of a run stays between 1 and 128 samples. An accepted change flips the stored level, while a rejected glitch leaves it alone. The overflow flag is sticky, and a pop from an empty queue leaves it empty. Whether the bytes carry the right lengths across spills, glitches, enable drops and different divider phases can only be seen from the bench's scenarios. There a behavioural model predicts every output on every cycle, and hand-computed byte values are compared at chosen points.

// File: rtl/irRlePkg.sv
`timescale 1ns/1ps
package irRlePkg;

  // Strobes sent from the control FSM to the run-length datapath
  typedef struct packed {
    logic tick;       // sample tick this cycle
    logic clear;      // capture disabled: drop partial run
    logic primeLoad;  // take idle level on this tick
    logic hunting;    // level known, waiting for first accepted change
    logic recording;  // runs are being measured and emitted
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PRIME = 2'd1,
    ST_HUNT  = 2'd2,
    ST_RUN   = 2'd3
  } rxState_e;

endpackage

// File: rtl/irRleCtrl.sv
`timescale 1ns/1ps
module irRleCtrl
  import irRlePkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] sampleDiv,
  input  logic             accept,
  output ctlStrobes_t      strobes
);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  rxState_e         state, stateNext;

  assign tick = enable && (divCnt >= sampleDiv);

  // Sample-rate divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (!enable) divCnt <= '0;
    else if (tick)    divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  always_comb begin
    stateNext = state;
    if (!enable) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   stateNext = ST_PRIME;
        ST_PRIME: if (tick) stateNext = ST_HUNT;
        ST_HUNT:  if (accept) stateNext = ST_RUN;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.tick      = tick;
    strobes.clear     = !enable;
    strobes.primeLoad = (state == ST_PRIME);
    strobes.hunting   = (state == ST_HUNT);
    strobes.recording = (state == ST_RUN);
  end

  // R1: no tick while disabled
  p_tick_enabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> enable);

  // R1: consecutive ticks only with a zero divider
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && sampleDiv != '0) |=> (!tick || sampleDiv == '0));

  // R5: the priming tick moves on to hunting for the first change
  p_prime_to_hunt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRIME && tick) |=> (state == ST_HUNT || !enable));

endmodule

// File: rtl/irRleDatapath.sv
`timescale 1ns/1ps
module irRleDatapath
  import irRlePkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int LEN_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              irIn,
  input  logic [LEN_W-1:0]  noiseThr,
  output logic              accept,
  output logic              wrEn,
  output logic [DATA_W-1:0] wrData
);

  localparam int RUN_W   = LEN_W + 1;
  localparam int MAX_RUN = 1 << LEN_W;

  logic             curLvl;
  logic [RUN_W-1:0] runLen;     // samples since run start, glitch samples included
  logic [LEN_W-1:0] candCnt;    // consecutive samples of a not-yet-accepted level
  logic             diff;
  logic             thrMet;
  logic [RUN_W:0]   runInc;
  logic             spill;
  logic [RUN_W-1:0] confirmed;
  logic             active;

  assign active    = strobes.hunting || strobes.recording;
  assign diff      = irIn ^ curLvl;
  assign thrMet    = ({1'b0, candCnt} + RUN_W'(1)) >= {1'b0, noiseThr};
  assign accept    = strobes.tick && active && diff && thrMet;
  assign runInc    = {1'b0, runLen} + (RUN_W+1)'(1);
  assign spill     = runInc > (RUN_W+1)'(MAX_RUN);
  assign confirmed = runLen - {1'b0, candCnt};

  // Byte emission
  always_comb begin
    wrEn   = 1'b0;
    wrData = '0;
    if (strobes.tick && strobes.recording) begin
      if (diff && thrMet) begin
        wrEn   = 1'b1;
        wrData = {curLvl, LEN_W'(confirmed - RUN_W'(1))};
      end else if (!diff && spill) begin
        wrEn   = 1'b1;
        wrData = {curLvl, {LEN_W{1'b1}}};
      end
    end
  end

  // Run tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLvl  <= 1'b0;
      runLen  <= '0;
      candCnt <= '0;
    end else if (strobes.clear) begin
      runLen  <= '0;
      candCnt <= '0;
    end else if (strobes.tick) begin
      if (strobes.primeLoad) begin
        curLvl  <= irIn;
        runLen  <= '0;
        candCnt <= '0;
      end else if (active) begin
        if (diff) begin
          if (thrMet) begin
            curLvl  <= irIn;
            runLen  <= {1'b0, candCnt} + RUN_W'(1);
            candCnt <= '0;
          end else begin
            candCnt <= candCnt + LEN_W'(1);
            if (strobes.recording) runLen <= runLen + RUN_W'(1);
          end
        end else begin
          candCnt <= '0;
          if (strobes.recording)
            runLen <= spill ? RUN_W'(runInc - (RUN_W+1)'(MAX_RUN)) : RUN_W'(runInc);
        end
      end
    end
  end

  // R3: the confirmed part of a run always fits one byte code
  p_run_bounds_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.recording |-> (runLen > {1'b0, candCnt}) &&
                          ((runLen - {1'b0, candCnt}) <= RUN_W'(MAX_RUN)));

  // R2: an accepted change flips the stored polarity
  p_accept_flips_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && strobes.recording) |=> (curLvl != $past(curLvl)));

  // R4: a change below the noise threshold leaves the level alone
  p_glitch_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && active && !strobes.primeLoad && diff && !thrMet) |=> $stable(curLvl));

endmodule

// File: rtl/irRleFifo.sv
`timescale 1ns/1ps
module irRleFifo #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LVL_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              ovfClr,
  input  logic [LVL_W-1:0]  fifoThr,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              irq,
  output logic              overflow
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  count;
  logic              full, doWr, doRd;

  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign level  = count;
  assign rdData = mem[rdPtr];
  assign irq    = (fifoThr != '0) && (count >= fifoThr);

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doWr) wrPtr <= wrPtr + PTR_W'(1);
      if (doRd) rdPtr <= rdPtr + PTR_W'(1);
      count <= count + LVL_W'(doWr) - LVL_W'(doRd);
      if (wrEn && full) overflow <= 1'b1;
      else if (ovfClr)  overflow <= 1'b0;
    end
  end

  // R9: a byte arriving at a full queue raises the flag
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full) |=> overflow);

  // R9: the flag holds until cleared
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClr) |=> overflow);

  // R7: popping an empty queue leaves it empty
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty && !wrEn) |=> empty);

  // R7: the level never exceeds the depth
  p_level_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= LVL_W'(DEPTH));

endmodule

// File: rtl/irRleRx.sv
`timescale 1ns/1ps
module irRleRx
  import irRlePkg::*;
#(
  parameter  int DIV_W      = 12,
  parameter  int DATA_W     = 8,
  parameter  int FIFO_DEPTH = 64,
  localparam int LEN_W      = DATA_W - 1,
  localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              irIn,
  input  logic [DIV_W-1:0]  sampleDiv,
  input  logic [LEN_W-1:0]  noiseThr,
  input  logic [LVL_W-1:0]  fifoThr,
  input  logic              rdEn,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoIrq,
  output logic              overflow
);

  ctlStrobes_t       strobes;
  logic              accept;
  logic              wrEn;
  logic [DATA_W-1:0] wrData;

  irRleCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sampleDiv (sampleDiv),
    .accept    (accept),
    .strobes   (strobes)
  );

  irRleDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .irIn     (irIn),
    .noiseThr (noiseThr),
    .accept   (accept),
    .wrEn     (wrEn),
    .wrData   (wrData)
  );

  irRleFifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .ovfClr   (ovfClr),
    .fifoThr  (fifoThr),
    .rdData   (rdData),
    .empty    (fifoEmpty),
    .level    (fifoLevel),
    .irq      (fifoIrq),
    .overflow (overflow)
  );

endmodule

// File: tb/irRleRx_bench.sv
`timescale 1ns/1ps
module irRleRx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        irIn = 1'b1;
  logic [11:0] sampleDiv = '0;
  logic [6:0]  noiseThr = '0;
  logic [6:0]  fifoThr = '0;
  logic        rdEn = 1'b0;
  logic        ovfClr = 1'b0;
  logic [7:0]  rdData;
  logic        fifoEmpty;
  logic [6:0]  fifoLevel;
  logic        fifoIrq;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R10 reset";

  always #2 clk = ~clk;  // 250 MHz

  irRleRx u_irRleRx (
    .clk(clk), .rstN(rstN), .enable(enable), .irIn(irIn),
    .sampleDiv(sampleDiv), .noiseThr(noiseThr), .fifoThr(fifoThr),
    .rdEn(rdEn), .ovfClr(ovfClr), .rdData(rdData), .fifoEmpty(fifoEmpty),
    .fifoLevel(fifoLevel), .fifoIrq(fifoIrq), .overflow(overflow)
  );

  // Behavioural reference model
  int   mDiv = 0, mState = 0, mCand = 0, mRun = 0;
  bit   mLvl = 0, mOvf = 0;
  logic [7:0] q[$];

  always @(posedge clk) begin
    int  pushVal;
    bit  tk, wasFull;
    pushVal = -1;
    if (!rstN) begin
      mDiv = 0; mState = 0; mCand = 0; mRun = 0; mLvl = 0; mOvf = 0;
      q.delete();
    end else begin
      tk = enable && (mDiv >= int'(sampleDiv));
      if (!enable) begin
        mState = 0; mCand = 0; mRun = 0;
      end else if (mState == 0) begin
        mState = 1;
      end else if (mState == 1) begin
        if (tk) begin mLvl = irIn; mCand = 0; mRun = 0; mState = 2; end
      end else if (tk) begin
        if (irIn != mLvl) begin
          if (mCand + 1 >= int'(noiseThr)) begin
            if (mState == 3) pushVal = mLvl * 128 + (mRun - mCand - 1);
            mLvl = irIn; mRun = mCand + 1; mCand = 0; mState = 3;
          end else begin
            mCand++;
            if (mState == 3) mRun++;
          end
        end else begin
          mCand = 0;
          if (mState == 3) begin
            mRun++;
            if (mRun > 128) begin pushVal = mLvl * 128 + 127; mRun -= 128; end
          end
        end
      end
      if (!enable || tk) mDiv = 0; else mDiv++;
      wasFull = (q.size() == 64);
      if (rdEn && q.size() > 0) void'(q.pop_front());
      if (ovfClr) mOvf = 0;
      if (pushVal >= 0) begin
        if (wasFull) mOvf = 1;
        else q.push_back(8'(pushVal));
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #0.5;
    if (!done) begin
      check("R7 fifoEmpty", int'(fifoEmpty), int'(q.size() == 0));
      check("R7 fifoLevel", int'(fifoLevel), q.size());
      check("R8 fifoIrq", int'(fifoIrq), int'(fifoThr != 0 && q.size() >= int'(fifoThr)));
      check("R9 overflow", int'(overflow), int'(mOvf));
      if (q.size() > 0) check("R2 rdData", int'(rdData), int'(q[0]));
    end
  end

  task automatic hold(bit lvl, int n);
    irIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic stopCapture();
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check("R10 reset empty", int'(fifoEmpty), 1);
    check("R10 reset level", int'(fifoLevel), 0);
    check("R10 reset overflow", int'(overflow), 0);
    check("R10 reset irq", int'(fifoIrq), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R5: spill of a 130-sample low run, idle level not recorded
    phase = "R3 spill";
    sampleDiv = 0; noiseThr = 0; fifoThr = 0;
    enable = 1'b1;
    hold(1, 6);
    hold(0, 130);
    hold(1, 5);
    stopCapture();
    #0.5;
    check("R5 idle level gives no byte", int'(fifoLevel), 2);
    check("R3 spill byte", int'(rdData), 8'h7f);
    @(negedge clk);
    pop();
    #0.5;
    check("R2 remainder byte", int'(rdData), 8'h01);
    @(negedge clk);
    pop();

    // R4: glitch samples absorbed into the current run
    phase = "R4 noise";
    noiseThr = 4;
    enable = 1'b1;
    hold(0, 5);
    hold(1, 8);
    hold(0, 2);
    hold(1, 6);
    hold(0, 10);
    stopCapture();
    #0.5;
    check("R4 one byte after glitch", int'(fifoLevel), 1);
    check("R4 glitch counted in run", int'(rdData), 8'h8f);
    @(negedge clk);
    pop();

    // R1: divided sample rate
    phase = "R1 divider";
    noiseThr = 0; sampleDiv = 3;
    enable = 1'b1;
    hold(1, 20);
    hold(0, 40);
    hold(1, 12);
    stopCapture();
    #0.5;
    check("R1 ticks per run", int'(rdData), 8'h09);
    @(negedge clk);
    pop();

    // R6: disable drops the partial run
    phase = "R6 disable";
    sampleDiv = 0;
    enable = 1'b1;
    hold(1, 3);
    hold(0, 20);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    hold(0, 5);
    hold(1, 4);
    hold(0, 2);
    stopCapture();
    #0.5;
    check("R6 partial run dropped", int'(fifoLevel), 1);
    check("R6 byte after restart", int'(rdData), 8'h83);
    @(negedge clk);
    pop();

    // R9, R8, R7: overflow, threshold interrupt, empty pops
    phase = "R9 overflow";
    fifoThr = 10;
    enable = 1'b1;
    for (int i = 0; i < 90; i++) hold(i[0], 1);
    stopCapture();
    #0.5;
    check("R9 full level", int'(fifoLevel), 64);
    check("R9 overflow set", int'(overflow), 1);
    check("R8 irq at full", int'(fifoIrq), 1);
    @(negedge clk);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    #0.5;
    check("R9 overflow cleared", int'(overflow), 0);
    @(negedge clk);
    phase = "R8 threshold";
    rdEn = 1'b1;
    repeat (60) @(negedge clk);
    rdEn = 1'b0;
    #0.5;
    check("R8 irq below threshold", int'(fifoIrq), 0);
    @(negedge clk);
    fifoThr = 4;
    #0.5;
    check("R8 irq at threshold", int'(fifoIrq), 1);
    @(negedge clk);
    fifoThr = 0;
    #0.5;
    check("R8 irq disabled by zero", int'(fifoIrq), 0);
    @(negedge clk);
    phase = "R7 empty pops";
    rdEn = 1'b1;
    repeat (7) @(negedge clk);
    rdEn = 1'b0;
    #0.5;
    check("R7 empty after extra pops", int'(fifoEmpty), 1);
    check("R7 level zero", int'(fifoLevel), 0);
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule